// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns bytes offered on a valid/ready input into asynchronous serial characters on a single line. An external baud generator supplies two strobes. The bit tick marks the boundary of every bit period. The sample tick runs at 16 or 13 times the bit rate and is used only to time a half stop bit. Character length, parity and stop length are set by static inputs. The block captures them at the moment it accepts a byte, so the next character can use a different format.

The sender can be held back in two ways. A clear-to-send input can stop it, and so can an xoff-state input driven by the receive side. The gate is only consulted before a character is accepted. A character that has already been accepted is always sent to its end. A break request holds the line low for as long as it is asserted. When it is released, the line is held in the marking state for a full recovery period before the next character can go out.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, and whenever no character or break is in progress, tx_o is high. ready_o is high only in that idle state, with the flow gate open and break_i low.
- R2: A character is one low start bit followed by the data bits, LSB first. The count of data bits is set by data_len_i: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R3: parity_i 01 appends a bit that makes the count of ones in data plus parity even. parity_i 10 makes that count odd. 00 and 11 append no parity bit.
- R4: stop_i 00 sends one high stop bit and stop_i 10 or 11 sends two. Counting from the cycle the start bit begins, ready_o returns exactly (1 + data bits + parity bits + stop bits) bit intervals later.
- R5: stop_i 01 sends one stop bit followed by a half bit. The half bit is 8 sample ticks when osr_alt_i is 0 and 6 when it is 1. ready_o returns exactly that many cycles after the full stop bit ends, with one sample tick per cycle.
- R6: After a byte is accepted, tx_o falls on the first bit tick. Every bit then lasts exactly one bit-tick interval.
- R7: When break_i is high in the idle state, tx_o is low and ready_o is low for as long as it stays high. If break_i rises during a character, the break starts only after that character's stop period.
- R8: After break_i falls, tx_o is high and ready_o stays low. This lasts until a bit tick has passed and then one further stop period of the selected length.
- R9: While hw_flow_en_i is high and cts_i is low, ready_o is low and no character starts. A pending byte is accepted once cts_i goes high.
- R10: While sw_flow_en_i is high and xoff_i is high, ready_o is low and no character starts. A pending byte is accepted once xoff_i goes low.
- R11: A character that has been accepted is sent in full, even if cts_i falls or xoff_i rises while it is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_len_i | input | 2 | Data bit count select (5 to 8) |
| parity_i | input | 2 | Parity select: none, even, odd |
| stop_i | input | 2 | Stop length select: 1, 1.5, 2 |
| osr_alt_i | input | 1 | 1 selects 13 sample ticks per bit, 0 selects 16 |
| hw_flow_en_i | input | 1 | Enables clear-to-send gating |
| sw_flow_en_i | input | 1 | Enables xoff gating |
| cts_i | input | 1 | Clear to send, high allows a start |
| xoff_i | input | 1 | Remote requested pause, high blocks a start |
| break_i | input | 1 | Break request |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | data_i is valid |
| ready_o | output | 1 | Byte is accepted this cycle when valid_i is high |
| bit_tick_i | input | 1 | One-cycle strobe at each bit boundary |
| sample_tick_i | input | 1 | Oversampling strobe |
| tx_o | output | 1 | Serial line |

## Verification
The start bit appears between 1 and one full bit interval after the accepting edge, depending on where the next bit tick falls. The bench measures that gap at the line. Every later bit is sampled at the middle of its bit interval, counted in falling edges from the observed start edge. The return of ready_o is checked one cycle before and exactly at its predicted cycle, which is a whole number of bit intervals after the start edge, plus 8 or 6 cycles for a half stop. Break and gating checks sample every cycle of a window and allow for the tick phase, since the release and gate-open edges are not aligned to the bit grid.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned MIN_DATA_BITS = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_START, ST_DATA, ST_PARITY,
    ST_STOP, ST_HALF, ST_BREAK, ST_BRK_END
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_OFF = 2'd3
  } parity_e;

  typedef enum logic [1:0] {
    STOP_ONE = 2'd0, STOP_ONE_HALF = 2'd1, STOP_TWO = 2'd2, STOP_TWO_ALT = 2'd3
  } stop_e;

  typedef struct packed {
    logic [1:0] len;
    parity_e    par;
    stop_e      stop;
    logic       osr_alt;
  } tx_cfg_t;

endpackage

// File: rtl/uart_tx_flow_gate.sv
module uart_tx_flow_gate (
  input  logic hw_en_i,
  input  logic sw_en_i,
  input  logic cts_i,
  input  logic xoff_i,
  output logic open_o
);

  logic hw_ok, sw_ok;

  assign hw_ok  = !hw_en_i || cts_i;
  assign sw_ok  = !sw_en_i || !xoff_i;
  assign open_o = hw_ok && sw_ok;

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        len_i,
  input  parity_e           par_i,
  output logic              bit_o,
  output logic              par_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] sh_q, mask, masked;
  logic [CNT_W-1:0]  nbits;
  logic              par_q;

  assign nbits = CNT_W'(MIN_DATA_BITS) + CNT_W'(len_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = CNT_W'(i) < nbits;
  end

  assign masked = data_i & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      par_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= masked;
      par_q <= (^masked) ^ (par_i == PAR_ODD);
    end else if (shift_i) begin
      sh_q  <= sh_q >> 1;
    end
  end

  assign bit_o = sh_q[0];
  assign par_o = par_q;

endmodule

// File: rtl/uart_tx_half_timer.sv
module uart_tx_half_timer #(
  parameter int unsigned OSR_STD = 16,
  parameter int unsigned OSR_ALT = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_tick_i,
  input  logic osr_alt_i,
  output logic done_o
);

  localparam int unsigned CNT_W    = $clog2(OSR_STD);
  localparam int unsigned HALF_STD = OSR_STD / 2;
  localparam int unsigned HALF_ALT = OSR_ALT / 2;

  logic [CNT_W-1:0] cnt_q, last;

  assign last = osr_alt_i ? CNT_W'(HALF_ALT - 1) : CNT_W'(HALF_STD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (sample_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = !clear_i && sample_tick_i && (cnt_q == last);

  AST_HALF_WITHIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> cnt_q <= last); // R5

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  tx_cfg_t cfg_i,
  input  logic    valid_i,
  input  logic    gate_open_i,
  input  logic    break_i,
  input  logic    bit_tick_i,
  input  logic    half_done_i,
  input  logic    data_bit_i,
  input  logic    par_bit_i,
  output logic    ready_o,
  output logic    load_o,
  output logic    shift_o,
  output logic    half_clear_o,
  output logic    osr_alt_o,
  output logic    tx_o
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  tx_state_e        state_q, state_d;
  tx_cfg_t          cfg_q;
  logic [IDX_W-1:0] idx_q, idx_d, last_idx;
  logic             stop2_q, stop2_d;
  logic             par_en, two_stop, half_stop;

  assign last_idx  = IDX_W'(MIN_DATA_BITS - 1) + IDX_W'(cfg_q.len);
  assign par_en    = (cfg_q.par == PAR_EVEN) || (cfg_q.par == PAR_ODD);
  assign two_stop  = (cfg_q.stop == STOP_TWO) || (cfg_q.stop == STOP_TWO_ALT);
  assign half_stop = cfg_q.stop == STOP_ONE_HALF;

  assign ready_o      = (state_q == ST_IDLE) && !break_i && gate_open_i;
  assign load_o       = valid_i && ready_o;
  assign shift_o      = (state_q == ST_DATA) && bit_tick_i && (idx_q != last_idx);
  assign half_clear_o = state_q != ST_HALF;
  assign osr_alt_o    = cfg_q.osr_alt;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    stop2_d = stop2_q;
    unique case (state_q)
      ST_IDLE: begin
        if (break_i)     state_d = ST_BREAK;
        else if (load_o) state_d = ST_ARM;
      end
      ST_ARM: if (bit_tick_i) state_d = ST_START;
      ST_START: if (bit_tick_i) begin
        state_d = ST_DATA;
        idx_d   = '0;
      end
      ST_DATA: if (bit_tick_i) begin
        if (idx_q == last_idx) begin
          state_d = par_en ? ST_PARITY : ST_STOP;
          stop2_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_PARITY: if (bit_tick_i) begin
        state_d = ST_STOP;
        stop2_d = 1'b0;
      end
      ST_STOP: if (bit_tick_i) begin
        if (two_stop && !stop2_q) stop2_d = 1'b1;
        else if (half_stop)       state_d = ST_HALF;
        else                      state_d = ST_IDLE;
      end
      ST_HALF: if (half_done_i) state_d = ST_IDLE;
      ST_BREAK: if (!break_i) state_d = ST_BRK_END;
      ST_BRK_END: if (bit_tick_i) begin
        state_d = ST_STOP;
        stop2_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      stop2_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      stop2_q <= stop2_d;
      if (state_q == ST_IDLE) cfg_q <= cfg_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START, ST_BREAK: tx_o = 1'b0;
      ST_DATA:            tx_o = data_bit_i;
      ST_PARITY:          tx_o = par_bit_i;
      default:            tx_o = 1'b1;
    endcase
  end

  AST_ARM_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> tx_o); // R6

  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !bit_tick_i) |=> $stable(tx_o)); // R2

  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BREAK && break_i) |=> !tx_o && !ready_o); // R7

  AST_BREAK_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BREAK && !break_i) |=> tx_o && !ready_o); // R8

  AST_HALF_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALF && half_done_i) |=> state_q == ST_IDLE); // R5

  AST_FRAME_NOT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && !bit_tick_i) |=> state_q == ST_START); // R11

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OSR_STD = 16,
  parameter int unsigned OSR_ALT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        data_len_i,
  input  logic [1:0]        parity_i,
  input  logic [1:0]        stop_i,
  input  logic              osr_alt_i,
  input  logic              hw_flow_en_i,
  input  logic              sw_flow_en_i,
  input  logic              cts_i,
  input  logic              xoff_i,
  input  logic              break_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              bit_tick_i,
  input  logic              sample_tick_i,
  output logic              tx_o
);

  tx_cfg_t cfg;
  logic gate_open, load, shift, half_clear, half_done, osr_alt_q, data_bit, par_bit;

  assign cfg.len     = data_len_i;
  assign cfg.par     = parity_e'(parity_i);
  assign cfg.stop    = stop_e'(stop_i);
  assign cfg.osr_alt = osr_alt_i;

  uart_tx_flow_gate i_gate (
    .hw_en_i (hw_flow_en_i),
    .sw_en_i (sw_flow_en_i),
    .cts_i   (cts_i),
    .xoff_i  (xoff_i),
    .open_o  (gate_open)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .data_i  (data_i),
    .len_i   (cfg.len),
    .par_i   (cfg.par),
    .bit_o   (data_bit),
    .par_o   (par_bit)
  );

  uart_tx_half_timer #(.OSR_STD(OSR_STD), .OSR_ALT(OSR_ALT)) i_half (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (half_clear),
    .sample_tick_i (sample_tick_i),
    .osr_alt_i     (osr_alt_q),
    .done_o        (half_done)
  );

  uart_tx_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .valid_i      (valid_i),
    .gate_open_i  (gate_open),
    .break_i      (break_i),
    .bit_tick_i   (bit_tick_i),
    .half_done_i  (half_done),
    .data_bit_i   (data_bit),
    .par_bit_i    (par_bit),
    .ready_o      (ready_o),
    .load_o       (load),
    .shift_o      (shift),
    .half_clear_o (half_clear),
    .osr_alt_o    (osr_alt_q),
    .tx_o         (tx_o)
  );

endmodule

// File: tb/test_uart_tx_core.sv
`timescale 1ns/1ps
module test_uart_tx_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] data_len = 2'd3, parity = 2'd0, stop = 2'd0;
  logic       osr_alt = 1'b0, hw_en = 1'b0, sw_en = 1'b0, cts = 1'b1, xoff = 1'b0, brk = 1'b0;
  logic [7:0] data = 8'h00;
  logic       valid = 1'b0, bit_tick = 1'b0, sample_tick = 1'b1;
  logic       ready, tx;

  always #2 clk = ~clk;

  uart_tx_core i_uart_tx_core (
    .clk_i(clk), .rst_ni(rst_n), .data_len_i(data_len), .parity_i(parity), .stop_i(stop),
    .osr_alt_i(osr_alt), .hw_flow_en_i(hw_en), .sw_flow_en_i(sw_en), .cts_i(cts), .xoff_i(xoff),
    .break_i(brk), .data_i(data), .valid_i(valid), .ready_o(ready), .bit_tick_i(bit_tick),
    .sample_tick_i(sample_tick), .tx_o(tx)
  );

  int bit_cyc = 16;
  int tick_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always @(negedge clk) begin
    tick_cnt = (tick_cnt >= bit_cyc - 1) ? 0 : tick_cnt + 1;
    bit_tick = (tick_cnt == bit_cyc - 1);
  end

  typedef struct {
    logic [7:0] d;
    int n;
    int par;
    int stp;
    int bitc;
    bit chk_ready;
  } item_t;

  item_t q[$];
  bit mon_busy = 0;
  logic prev_tx = 1'b1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(item_t it);
    int pb, ns, half, nb, m, e;
    logic [15:0] expv, got, msk;
    logic [7:0] dm;
    pb   = (it.par == 1 || it.par == 2) ? 1 : 0;
    ns   = (it.stp >= 2) ? 2 : 1;
    half = (it.stp == 1) ? it.bitc / 2 : 0;
    nb   = 1 + it.n + pb + ns;
    dm   = it.d & 8'((1 << it.n) - 1);
    expv = '0;
    for (int i = 0; i < it.n; i++) expv[1 + i] = dm[i];
    if (pb == 1) expv[1 + it.n] = (^dm) ^ (it.par == 2);
    for (int s = 0; s < ns; s++) expv[1 + it.n + pb + s] = 1'b1;
    got = '0;
    m = 0;
    for (int b = 0; b < nb; b++) begin
      while (m < b * it.bitc + it.bitc / 2) begin
        @(negedge clk);
        m++;
      end
      got[b] = tx;
    end
    msk = 16'((1 << nb) - 1);
    chk((got & msk) == (expv & msk), "R2/R3/R6 frame bits", int'(got & msk), int'(expv & msk));
    if (it.chk_ready) begin
      e = nb * it.bitc + half;
      while (m < e - 1) begin
        @(negedge clk);
        m++;
      end
      chk(ready == 1'b0, "R4/R5 ready early", int'(ready), 0);
      @(negedge clk);
      chk(ready == 1'b1, "R4/R5 ready due", int'(ready), 1);
    end
  endtask

  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && prev_tx && !tx && q.size() > 0) begin
        it = q.pop_front();
        mon_busy = 1;
        run_frame(it);
        mon_busy = 0;
      end
      prev_tx = tx;
    end
  end

  task automatic send(logic [7:0] d, bit chk_rdy);
    item_t it;
    int w;
    it.d = d; it.n = int'(data_len) + 5; it.par = int'(parity); it.stp = int'(stop);
    it.bitc = bit_cyc; it.chk_ready = chk_rdy;
    @(negedge clk);
    data = d;
    valid = 1'b1;
    while (!ready) @(negedge clk);
    q.push_back(it);
    @(negedge clk);
    valid = 1'b0;
    w = 1;
    while (tx && w <= bit_cyc + 1) begin
      @(negedge clk);
      w++;
    end
    chk(w >= 1 && w <= bit_cyc, "R6 start delay", w, bit_cyc);
  endtask

  task automatic wait_idle();
    wait (q.size() == 0 && !mon_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic blocked_window(string tag);
    bit ok = 1;
    repeat (4 * 16) begin
      @(negedge clk);
      if (!tx || ready) ok = 0;
    end
    chk(ok, tag, int'(ready), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    int w;
    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R1 tx in reset", int'(tx), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx == 1'b1 && ready == 1'b1, "R1 idle after reset", int'({tx, ready}), 3);

    // 8 bits, no parity, 1 stop, back to back
    send(8'hA5, 1);
    send(8'h3C, 1);
    wait_idle();
    // 5 bits, even parity, 2 stop; upper bits dropped
    data_len = 2'd0; parity = 2'd1; stop = 2'd2;
    send(8'h1D, 1);
    send(8'hFF, 1);
    wait_idle();
    // 6 bits, odd parity, 1.5 stop
    data_len = 2'd1; parity = 2'd2; stop = 2'd1;
    send(8'h2A, 1);
    wait_idle();
    // 7 bits, parity code 11 is none, stop code 11 is two
    data_len = 2'd2; parity = 2'd3; stop = 2'd3;
    send(8'h55, 1);
    wait_idle();
    // 13x oversampling, R5 half = 6
    bit_cyc = 13; osr_alt = 1'b1;
    data_len = 2'd3; parity = 2'd1; stop = 2'd1;
    send(8'h81, 1);
    parity = 2'd2; stop = 2'd0;
    send(8'h7E, 1);
    wait_idle();
    bit_cyc = 16; osr_alt = 1'b0;
    data_len = 2'd3; parity = 2'd0; stop = 2'd0;
    repeat (20) @(negedge clk);

    // R9 hardware gate
    hw_en = 1'b1; cts = 1'b0;
    fork
      send(8'h96, 1);
      begin
        blocked_window("R9 cts low blocks start");
        cts = 1'b1;
      end
    join
    wait_idle();
    // R11 cts drop mid frame
    fork
      send(8'h5A, 0);
      begin
        wait (mon_busy);
        repeat (20) @(negedge clk);
        cts = 1'b0;
      end
    join
    wait (!mon_busy);
    repeat (3 * 16) @(negedge clk);
    chk(ready == 1'b0 && tx == 1'b1, "R9/R11 idle held after frame", int'({tx, ready}), 2);
    cts = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R9 ready after cts", int'(ready), 1);
    hw_en = 1'b0;

    // R10 software gate
    sw_en = 1'b1; xoff = 1'b1;
    fork
      send(8'h69, 1);
      begin
        blocked_window("R10 xoff blocks start");
        xoff = 1'b0;
      end
    join
    wait_idle();
    fork
      send(8'hE1, 0);
      begin
        wait (mon_busy);
        repeat (40) @(negedge clk);
        xoff = 1'b1;
      end
    join
    wait (!mon_busy);
    repeat (3 * 16) @(negedge clk);
    chk(ready == 1'b0 && tx == 1'b1, "R10/R11 xoff after frame", int'({tx, ready}), 2);
    xoff = 1'b0; sw_en = 1'b0;
    wait_idle();

    // R7 break from idle
    brk = 1'b1;
    ok = 1;
    repeat (3 * 16) begin
      @(negedge clk);
      if (tx || ready) ok = 0;
    end
    chk(ok, "R7 break holds line low", int'({tx, ready}), 0);
    brk = 1'b0;
    ok = 1;
    repeat (16) begin
      @(negedge clk);
      if (!tx || ready) ok = 0;
    end
    chk(ok, "R8 recovery after break", int'({tx, ready}), 2);
    w = 0;
    while (!ready && w < 40) begin
      @(negedge clk);
      w++;
    end
    chk(ready == 1'b1 && tx == 1'b1, "R8 ready after recovery", int'({tx, ready}), 3);

    // R7 break requested mid frame
    fork
      send(8'hC3, 0);
      begin
        wait (mon_busy);
        repeat (30) @(negedge clk);
        brk = 1'b1;
      end
    join
    wait (!mon_busy);
    w = 0;
    while (tx && w < 40) begin
      @(negedge clk);
      w++;
    end
    chk(tx == 1'b0, "R7 break after frame", int'(tx), 0);
    brk = 1'b0;
    w = 0;
    while (!ready && w < 80) begin
      @(negedge clk);
      w++;
    end
    chk(ready == 1'b1, "R8 ready after late break", int'(ready), 1);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule